// File: doc/BRIEF.md
# Parallel EEPROM Page-Load Sequencer

This block is a synchronous, device-side model of the write path of a byte-wide parallel EEPROM with 17-bit addressing. It samples the active-low chip-enable, write-enable and output-enable pins through two-flop synchronisers. It takes the address when a write cycle opens and the data when it closes. Each accepted byte goes into a page buffer. Bits 16 to 8 of the address select the page, and bits 7 to 0 select the byte within it.

The first accepted byte locks the page. Further bytes for the same page keep it open, as long as each new write-enable fall comes within a window measured from the previous one. When the window runs out, an internal programming cycle of fixed length begins and the busy flag is raised. At the end of that cycle a one-cycle commit strobe copies every loaded byte into a small register-file array. Bytes of the page that were not loaded keep their old contents. A load that names a different page is dropped and sets a sticky error flag. Loads made while programming is in progress are dropped as well.

The model keeps only a parameterised number of pages in its array, selected by the low bits of the page address. The read port returns the byte stored at the address pins one clock later.

Top module: `eeprom_page_loader`

## Requirements
- R1: A write cycle is open only while chip-enable and write-enable are both low and output-enable is high; with output-enable low, strobing the other two stores nothing and opens no page.
- R2: The address is taken when the write cycle opens, that is, on whichever of the chip-enable and write-enable falling edges comes later.
- R3: The data byte is taken when the write cycle closes, that is, on whichever of the chip-enable and write-enable rising edges comes first.
- R4: The page stays open while each new write-enable fall arrives within WIN_CYC clocks of the previous one. If none arrives, busy rises exactly WIN_CYC+3 clocks after the last write-enable fall is applied at the pins.
- R5: The first byte locks page address bits 16..8. A later load carrying another page address is not stored and sets page_err, which stays high until reset.
- R6: Busy stays high for exactly PROG_CYC clocks. In the clock where it falls, commit is high for that single clock.
- R7: A write cycle made while busy is high is ignored: it stores nothing and opens no new page.
- R8: A page may hold from 1 to 256 loaded bytes. On commit, exactly the loaded offsets of the locked page change, and the other offsets keep their previous values.
- R9: dout returns the array byte at address bits [ARR_W-1:0] one clock after the address is applied.
- R10: Reset sets busy, commit and page_err to zero and clears the whole array to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous to clk |
| we_n | input | 1 | Write enable, active low, asynchronous to clk |
| oe_n | input | 1 | Output enable, active low, asynchronous to clk |
| addr | input | 17 | Byte address; bits 16..8 give the page |
| din | input | 8 | Write data byte |
| dout | output | 8 | Registered read of the array at addr |
| busy | output | 1 | Internal programming cycle in progress |
| commit | output | 1 | One-clock strobe that writes the page into the array |
| page_err | output | 1 | Sticky flag for a load whose page differed from the locked page |

## Verification
A pin change made at a falling clock edge reaches the write logic after two synchroniser edges, and its effect is registered at the third rising edge. The bench therefore counts rising edges from the falling edge at which it drives the pins. It expects busy low after WIN_CYC+2 edges and high after WIN_CYC+3. From the edge where busy rose, it expects busy still high PROG_CYC-1 edges later, and busy low with commit high at PROG_CYC edges. A read is sampled one rising edge after the address is set. Data checks are made only after commit has fallen.

// File: rtl/eeprom_page_pkg.sv
// Package: shared types for the EEPROM page-load sequencer.
// Assumes: one state machine walks idle -> loading -> programming.
package eeprom_page_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOAD = 2'd1,
        PG_PROG = 2'd2
    } pg_state_t;

endpackage

// File: rtl/eeprom_pin_sync.sv
// Module: eeprom_pin_sync
// What: two-flop synchroniser for a bundle of asynchronous pins.
// Assumes: each bit is stable long enough to be sampled twice; RST_VAL is
//          the idle level of the bundle.
module eeprom_pin_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1;

    // Shift the pins through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            stage1 <= pin_i;
            sync_o <= stage1;
        end
    end

endmodule

// File: rtl/eeprom_load_ctl.sv
// Module: eeprom_load_ctl
// What: finds the start and end of each write cycle, locks the page, fills
//       the page buffer, times the byte-load window and the programming cycle.
// Assumes: inputs are already synchronised; ctl_s = {ce_n, we_n, oe_n}.
module eeprom_load_ctl
    import eeprom_page_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int OFS_W    = 8,
    parameter int WIN_CYC  = 5000,
    parameter int PROG_CYC = 250000,
    localparam int PG_W    = ADDR_W - OFS_W,
    localparam int PAGE_B  = 1 << OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             ctl_s,
    input  logic [ADDR_W-1:0]      addr_s,
    input  logic [7:0]             din_s,
    output logic                   busy,
    output logic                   commit,
    output logic                   page_err,
    output logic [PG_W-1:0]        lock_page,
    output logic [PAGE_B-1:0][7:0] page_data,
    output logic [PAGE_B-1:0]      page_mask
);

    localparam int MAXC  = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    pg_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic              wr_act, wr_act_d, wr_start, wr_stop;
    logic              loading;
    logic [OFS_W-1:0]  cur_off;
    logic [PG_W-1:0]   in_page;
    logic [OFS_W-1:0]  in_off;

    assign wr_act   = !ctl_s[2] && !ctl_s[1] && ctl_s[0];
    assign wr_start = wr_act && !wr_act_d;
    assign wr_stop  = !wr_act && wr_act_d;
    assign in_page  = addr_s[ADDR_W-1:OFS_W];
    assign in_off   = addr_s[OFS_W-1:0];
    assign busy     = (state == PG_PROG);

    // Remember last cycle's write-open level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_act_d <= 1'b0;
        else        wr_act_d <= wr_act;
    end

    // Page state machine, window and programming timers, page buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PG_IDLE;
            cnt       <= '0;
            loading   <= 1'b0;
            cur_off   <= '0;
            lock_page <= '0;
            page_err  <= 1'b0;
            commit    <= 1'b0;
            page_mask <= '0;
            page_data <= '0;
        end else begin
            commit <= 1'b0;
            case (state)
                PG_IDLE: begin
                    if (wr_start) begin
                        lock_page <= in_page;
                        cur_off   <= in_off;
                        loading   <= 1'b1;
                        page_mask <= '0;
                        cnt       <= '0;
                        state     <= PG_LOAD;
                    end
                end
                PG_LOAD: begin
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    if (wr_start) begin
                        if (in_page == lock_page) begin
                            cur_off <= in_off;
                            loading <= 1'b1;
                            cnt     <= '0;
                        end else begin
                            page_err <= 1'b1;
                        end
                    end else if (!wr_act && !loading && cnt >= WIN_LAST) begin
                        cnt   <= '0;
                        state <= PG_PROG;
                    end
                end
                PG_PROG: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == PROG_LAST) begin
                        cnt    <= '0;
                        commit <= 1'b1;
                        state  <= PG_IDLE;
                    end
                end
                default: state <= PG_IDLE;
            endcase
            if (wr_stop && loading) begin
                page_data[cur_off] <= din_s;
                page_mask[cur_off] <= 1'b1;
                loading            <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/eeprom_store.sv
// Module: eeprom_store
// What: register-file array; writes the masked page bytes on commit and
//       gives a registered read.
// Assumes: the low AIDX_W page bits pick one of ARR_PAGES stored pages.
module eeprom_store #(
    parameter int OFS_W     = 8,
    parameter int PG_W      = 9,
    parameter int ARR_PAGES = 4,
    localparam int AIDX_W   = $clog2(ARR_PAGES),
    localparam int ARR_W    = AIDX_W + OFS_W,
    localparam int ARR_B    = 1 << ARR_W,
    localparam int PAGE_B   = 1 << OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [PG_W-1:0]        lock_page,
    input  logic [PAGE_B-1:0][7:0] page_data,
    input  logic [PAGE_B-1:0]      page_mask,
    input  logic [ARR_W-1:0]       rd_idx,
    output logic [7:0]             dout
);

    logic [7:0] mem [ARR_B];

    // Clear on reset, write loaded bytes on commit, read one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARR_B; i++) mem[i] <= '0;
            dout <= '0;
        end else begin
            if (commit) begin
                for (int j = 0; j < PAGE_B; j++) begin
                    if (page_mask[j])
                        mem[{lock_page[AIDX_W-1:0], OFS_W'(j)}] <= page_data[j];
                end
            end
            dout <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/eeprom_page_loader.sv
// Module: eeprom_page_loader (top)
// What: synchronises the pins, runs the page-load sequencer and holds the
//       array.
// Assumes: addr/din are stable around the control edges that sample them.
module eeprom_page_loader #(
    parameter int ADDR_W    = 17,
    parameter int OFS_W     = 8,
    parameter int WIN_CYC   = 5000,
    parameter int PROG_CYC  = 250000,
    parameter int ARR_PAGES = 4,
    localparam int PG_W     = ADDR_W - OFS_W,
    localparam int PAGE_B   = 1 << OFS_W,
    localparam int ARR_W    = $clog2(ARR_PAGES) + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              busy,
    output logic              commit,
    output logic              page_err
);

    logic [2:0]              ctl_s;
    logic [ADDR_W+7:0]       bus_s;
    logic [PG_W-1:0]         lock_page;
    logic [PAGE_B-1:0][7:0]  page_data;
    logic [PAGE_B-1:0]       page_mask;

    eeprom_pin_sync #(.W(3), .RST_VAL(3'b111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .pin_i({ce_n, we_n, oe_n}), .sync_o(ctl_s)
    );

    eeprom_pin_sync #(.W(ADDR_W + 8), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .pin_i({addr, din}), .sync_o(bus_s)
    );

    eeprom_load_ctl #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_s(ctl_s),
        .addr_s(bus_s[ADDR_W+7:8]), .din_s(bus_s[7:0]),
        .busy(busy), .commit(commit), .page_err(page_err),
        .lock_page(lock_page), .page_data(page_data), .page_mask(page_mask)
    );

    eeprom_store #(.OFS_W(OFS_W), .PG_W(PG_W), .ARR_PAGES(ARR_PAGES)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .lock_page(lock_page),
        .page_data(page_data), .page_mask(page_mask),
        .rd_idx(addr[ARR_W-1:0]), .dout(dout)
    );

endmodule

// File: rtl/eeprom_page_loader_chk.sv
// Module: eeprom_page_loader_chk
// What: protocol assertions on the sequencer outputs, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module eeprom_page_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic commit,
    input logic page_err
);

    // R6: commit only in the clock right after a busy clock, with busy now low.
    a_r6_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!busy && $past(busy)));

    // R6: busy never falls without the commit strobe.
    a_r6_fall_has_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> commit);

    // R6: commit lasts one clock.
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R5: page_err is sticky.
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);

    // R10: reset clears the status outputs.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!busy && !commit && !page_err));

endmodule

bind eeprom_page_loader eeprom_page_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit), .page_err(page_err)
);

// File: tb/eeprom_page_loader_bench.sv
// Directed bench for eeprom_page_loader: one task per scenario.
module eeprom_page_loader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 40;
    localparam int PROG = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        busy, commit, page_err;
    int          checks = 0;
    int          errors = 0;

    eeprom_page_loader #(.WIN_CYC(WIN), .PROG_CYC(PROG), .ARR_PAGES(4)) u_eeprom_page_loader (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy), .commit(commit),
        .page_err(page_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_byte(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_chk(input logic [16:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        @(posedge clk); #1;
        check(dout, exp, req);
    endtask

    task automatic wait_busy(input logic lvl);
        for (int i = 0; i < 400; i++) begin
            if (busy == lvl) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_page_done();
        wait_busy(1'b1);
        wait_busy(1'b0);
        repeat (2) @(posedge clk);
        #1;
    endtask

    // R10: reset state.
    task automatic t_reset();
        #1;
        check(busy, 0, "R10 busy after reset");
        check(commit, 0, "R10 commit after reset");
        check(page_err, 0, "R10 page_err after reset");
        read_chk(17'h00105, 8'h00, "R10 array cleared");
    endtask

    // R4 R6 R8 R9: single byte, exact window and programming timing.
    task automatic t_single_byte();
        @(negedge clk);
        addr = 17'h00105; din = 8'hA5; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (WIN - 1) @(posedge clk); #1;
        check(busy, 0, "R4 busy low before window ends");
        @(posedge clk); #1;
        check(busy, 1, "R4 busy high at window end");
        repeat (PROG - 1) @(posedge clk); #1;
        check(busy, 1, "R6 busy held for PROG_CYC");
        @(posedge clk); #1;
        check(busy, 0, "R6 busy low after PROG_CYC");
        check(commit, 1, "R6 commit with busy fall");
        @(posedge clk); #1;
        check(commit, 0, "R6 commit one clock");
        read_chk(17'h00105, 8'hA5, "R9 R8 single byte stored");
        read_chk(17'h00104, 8'h00, "R8 neighbour untouched");
    endtask

    // R8: full 256-byte page kept open by loads inside the window.
    task automatic t_full_page();
        for (int i = 0; i < 256; i++) load_byte({9'd3, 8'(i)}, 8'(i) ^ 8'h5A);
        wait_page_done();
        for (int i = 0; i < 256; i++)
            read_chk({9'd3, 8'(i)}, 8'(i) ^ 8'h5A, "R8 full page byte");
    endtask

    // R1: output-enable low blocks the write.
    task automatic t_oe_block();
        @(negedge clk);
        addr = 17'h000A0; din = 8'h11; oe_n = 1'b0; we_n = 1'b0; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (WIN + 10) @(posedge clk); #1;
        check(busy, 0, "R1 no page opened with oe low");
        read_chk(17'h000A0, 8'h00, "R1 nothing stored with oe low");
    endtask

    // R2: address taken at the later falling edge (chip-enable last).
    task automatic t_addr_late_fall();
        @(negedge clk);
        addr = 17'h00010; din = 8'hB2; oe_n = 1'b1; we_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = 17'h00020; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        wait_page_done();
        read_chk(17'h00020, 8'hB2, "R2 later-fall address used");
        read_chk(17'h00010, 8'h00, "R2 earlier address unused");
    endtask

    // R3: data taken at the earlier rising edge (chip-enable first).
    task automatic t_data_early_rise();
        @(negedge clk);
        addr = 17'h00030; din = 8'hC1; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        din = 8'hD2; we_n = 1'b1;
        wait_page_done();
        read_chk(17'h00030, 8'hC1, "R3 earlier-rise data used");
    endtask

    // R5: load to another page is dropped and page_err sticks.
    task automatic t_page_mismatch();
        check(page_err, 0, "R5 page_err low before mismatch");
        load_byte(17'h00140, 8'h3C);
        load_byte(17'h00207, 8'h99);
        #1;
        check(page_err, 1, "R5 page_err set on mismatch");
        wait_page_done();
        read_chk(17'h00140, 8'h3C, "R5 locked page stored");
        read_chk(17'h00207, 8'h00, "R5 mismatched byte dropped");
        check(page_err, 1, "R5 page_err sticky");
    endtask

    // R7: loads while busy are ignored.
    task automatic t_busy_ignore();
        load_byte(17'h00050, 8'h77);
        wait_busy(1'b1);
        check(busy, 1, "R7 programming started");
        load_byte(17'h00051, 8'h88);
        wait_busy(1'b0);
        repeat (WIN + 10) @(posedge clk); #1;
        check(busy, 0, "R7 no page opened by busy load");
        read_chk(17'h00050, 8'h77, "R7 first byte stored");
        read_chk(17'h00051, 8'h00, "R7 busy load dropped");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_byte();
        t_full_page();
        t_oe_block();
        t_addr_late_fall();
        t_data_early_rise();
        t_page_mismatch();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule